// File: doc/BRIEF.md
# Packed Four-Lane Integer Arithmetic Unit

This unit takes two 64-bit operands, each holding four independent signed 16-bit lanes, and runs one lane-parallel operation on them per accepted strobe. It can add lane to lane with wrap or with clamping, multiply lane to lane into four full 32-bit products, add a single 16-bit scalar to every lane, or sum the four lanes of one operand into a running 32-bit accumulator. Lane k of the first operand pairs only with lane k of the second operand, and no carry passes from one lane into the next.

All results are registered and appear one clock after the input is accepted, together with a one-cycle output strobe. The accumulator keeps its value between strobes and is zeroed by a synchronous clear. When a clear arrives in the same cycle as a reduction, the accumulator is loaded with that reduction's sum alone.

Top module: `simd4x16_alu`

## Requirements
- R1: Lane k (k=0..3) is bits [16k+15:16k] of each 64-bit operand. With opcode 0, result[16k+15:16k] is (a lane k + b lane k) mod 2^16, and result[127:64] is zero.
- R2: With opcode 1, each lane sum is a signed value. A sum above 0x7FFF is clamped to 0x7FFF, and a sum below -0x8000 is clamped to 0x8000. result[127:64] is zero.
- R3: With opcode 2, result[32k+31:32k] is the signed 32-bit product of a lane k and b lane k.
- R4: With opcode 3, result[16k+15:16k] is (a lane k + scalar) mod 2^16, and result[127:64] is zero.
- R5: With opcode 4, the accumulator becomes acc + the sum of the four sign-extended lanes of a, modulo 2^32. The result bus shows the new accumulator in bits [31:0] and zero in all other bits.
- R6: When the clear input is high without a reduction, the accumulator reads zero on the next cycle. When clear and an opcode-4 strobe come together, the accumulator becomes that reduction's sum alone.
- R7: out_valid is high exactly in the cycle after in_valid is high with opcode 0 to 4. Opcodes 5 to 7 give no out_valid, and they leave the accumulator unchanged.
- R8: Carries never cross lanes. An overflow in one lane does not change any other lane's result.
- R9: After reset, out_valid is 0 and the accumulator is 0. Opcodes 0 to 3 never change the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| opcode | input | 3 | Operation select (0..4) |
| opa | input | 64 | First packed operand |
| opb | input | 64 | Second packed operand |
| scalar | input | 16 | Broadcast scalar |
| acc_clr | input | 1 | Synchronous accumulator clear |
| result | output | 128 | Registered result |
| acc | output | 32 | Accumulator value |
| out_valid | output | 1 | Result strobe |

## Verification
Two functions can land in the same cycle: the accumulator clear and a reduction. The bench drives acc_clr at random together with random opcodes, including invalid ones, so that clear arrives with reductions, with other operations and on idle cycles. A reference accumulator in the bench follows the clear-priority rule. The accumulator output is compared with it on every cycle, and the reduction result bus is compared with it on every strobe.

// File: rtl/simd4x16_alu.sv
module simd4x16_alu #(
  parameter int LANES = 4,
  parameter int LW    = 16,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2:0]            opcode,
  input  logic [LANES*LW-1:0]   opa,
  input  logic [LANES*LW-1:0]   opb,
  input  logic [LW-1:0]         scalar,
  input  logic                  acc_clr,
  output logic [LANES*2*LW-1:0] result,
  output logic [AW-1:0]         acc,
  output logic                  out_valid
);
  localparam int VW = LANES * LW;
  localparam int RW = LANES * 2 * LW;
  localparam logic signed [LW:0] SMAX = (LW+1)'((1 << (LW-1)) - 1);
  localparam logic signed [LW:0] SMIN = -(LW+1)'(1 << (LW-1));

  logic [VW-1:0] add_v, sat_v, scl_v;
  logic [RW-1:0] mul_v;
  logic [AW-1:0] red_sum;

  always_comb begin
    red_sum = '0;
    for (int k = 0; k < LANES; k++)
      red_sum = red_sum + AW'($signed(opa[k*LW +: LW]));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [LW-1:0] la, lb;
    logic signed [LW:0]   wsum;
    assign la = opa[k*LW +: LW];
    assign lb = opb[k*LW +: LW];
    assign wsum = {la[LW-1], la} + {lb[LW-1], lb};
    assign add_v[k*LW +: LW] = la + lb;
    assign scl_v[k*LW +: LW] = la + scalar;
    assign sat_v[k*LW +: LW] = (wsum > SMAX) ? SMAX[LW-1:0] :
                               (wsum < SMIN) ? SMIN[LW-1:0] : wsum[LW-1:0];
    assign mul_v[k*2*LW +: 2*LW] = la * lb;
  end

  logic          op_ok, is_red;
  logic [AW-1:0] acc_nxt;
  assign op_ok   = in_valid && (opcode <= 3'd4);
  assign is_red  = in_valid && (opcode == 3'd4);
  assign acc_nxt = (acc_clr ? '0 : acc) + red_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= op_ok;
      if (is_red)       acc <= acc_nxt;
      else if (acc_clr) acc <= '0;
      if (op_ok) begin
        case (opcode)
          3'd0:    result <= {{(RW-VW){1'b0}}, add_v};
          3'd1:    result <= {{(RW-VW){1'b0}}, sat_v};
          3'd2:    result <= mul_v;
          3'd3:    result <= {{(RW-VW){1'b0}}, scl_v};
          default: result <= {{(RW-AW){1'b0}}, acc_nxt};
        endcase
      end
    end
  end
endmodule

module simd4x16_alu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   opcode,
  input logic         acc_clr,
  input logic [127:0] result,
  input logic [31:0]  acc,
  input logic         out_valid
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= 3'd4) |=> out_valid);
  a_r7_no_valid_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && opcode <= 3'd4) |=> !out_valid);
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !(in_valid && opcode == 3'd4)) |=> $stable(acc));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !(in_valid && opcode == 3'd4)) |=> acc == 32'd0);
  a_r5_result_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd4) |=> (result[31:0] == acc && result[127:32] == 96'd0));
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 3'd0 || opcode == 3'd1 || opcode == 3'd3)) |=> result[127:64] == 64'd0);
endmodule

bind simd4x16_alu simd4x16_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .acc_clr(acc_clr), .result(result), .acc(acc), .out_valid(out_valid)
);

// File: tb/simd4x16_alu_tb.sv
module simd4x16_alu_tb;
  logic clk = 0, rst_n = 0, in_valid = 0, acc_clr = 0;
  logic [2:0] opcode = 0;
  logic [63:0] opa = 0, opb = 0;
  logic [15:0] scalar = 0;
  logic [127:0] result;
  logic [31:0] acc;
  logic out_valid;
  int checks = 0, fails = 0;
  logic [31:0] ref_acc = 0;

  always #2.5 clk = ~clk;

  simd4x16_alu u_dut (.clk, .rst_n, .in_valid, .opcode, .opa, .opb, .scalar,
                      .acc_clr, .result, .acc, .out_valid);

  function automatic logic [127:0] model(input logic [2:0] op, input logic [63:0] a,
      input logic [63:0] b, input logic [15:0] s, input logic [31:0] newacc);
    logic [127:0] r = 0;
    for (int k = 0; k < 4; k++) begin
      int sa = $signed(a[k*16 +: 16]);
      int sb = $signed(b[k*16 +: 16]);
      int t;
      case (op)
        0: r[k*16 +: 16] = 16'(sa + sb);
        1: begin
             t = sa + sb;
             if (t > 32767) t = 32767;
             if (t < -32768) t = -32768;
             r[k*16 +: 16] = 16'(t);
           end
        2: r[k*32 +: 32] = 32'(sa * sb);
        3: r[k*16 +: 16] = 16'(sa + int'(s));
        default: r = {96'd0, newacc};
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] lsum(input logic [63:0] a);
    logic [31:0] t = 0;
    for (int k = 0; k < 4; k++) t += 32'($signed(a[k*16 +: 16]));
    return t;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [63:0] a,
                      input logic [63:0] b, input logic [15:0] s, input logic clr, input string req);
    logic [127:0] exp;
    logic good;
    in_valid = v; opcode = op; opa = a; opb = b; scalar = s; acc_clr = clr;
    good = v && op <= 4;
    if (v && op == 4) ref_acc = (clr ? 32'd0 : ref_acc) + lsum(a);
    else if (clr) ref_acc = 0;
    exp = model(op, a, b, s, ref_acc);
    @(posedge clk); #1;
    chk({req, " valid R7"}, {127'd0, out_valid}, {127'd0, good});
    chk({req, " acc R6 R9"}, {96'd0, acc}, {96'd0, ref_acc});
    if (good) chk(req, result, exp);
    in_valid = 0; acc_clr = 0;
  endtask

  initial begin
    #20000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset valid", {127'd0, out_valid}, 128'd0);
    chk("R9 reset acc", {96'd0, acc}, 128'd0);
    rst_n = 1;
    step(1, 0, 64'h0001_0002_0003_FFFF, 64'h0000_0000_0000_0001, 0, 0, "R8 R1 lane0 carry");
    step(1, 0, 64'h7FFF_8000_0001_0000, 64'h0001_FFFF_FFFF_0000, 0, 0, "R1 wrap");
    step(1, 1, 64'h7FFF_8000_0010_7000, 64'h0001_FFFF_FFF0_1000, 0, 0, "R2 saturate");
    step(1, 1, 64'h7FFF_8000_7FFF_8000, 64'h7FFF_8000_0000_0000, 0, 0, "R2 extremes");
    step(1, 2, 64'h8000_FFFF_7FFF_0003, 64'h8000_0002_7FFF_FFFE, 0, 0, "R3 multiply");
    step(1, 3, 64'h0000_FFFF_7FFF_1234, 0, 16'h0001, 0, "R4 scalar");
    step(1, 4, 64'hFFFF_0001_0002_0003, 0, 0, 0, "R5 reduce");
    step(1, 4, 64'h8000_8000_8000_8000, 0, 0, 0, "R5 reduce neg");
    step(1, 5, 64'h1111_1111_1111_1111, 0, 0, 0, "R7 bad opcode");
    step(1, 2, 64'h1, 64'h1, 0, 0, "R9 no acc change");
    step(1, 4, 64'h0001_0001_0001_0001, 0, 0, 1, "R6 clear with reduce");
    step(0, 0, 0, 0, 0, 1, "R6 clear alone");
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      step(1'($urandom_range(0, 3) != 0), op, {$urandom, $urandom}, {$urandom, $urandom},
           16'($urandom), $urandom_range(0, 9) == 0, "R1 R3 R5 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule